// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns a four-bit power-control code from the processor status word into enables for five targets: the CPU, the main clock, the sub-main clock, the fast internal oscillator and the auxiliary clock. Software writes the code while the CPU runs. A code that asks for a low-power mode makes the block gate the matching domains, and the CPU then stops.

A qualified interrupt request wakes the device. On entry the block keeps the live code in a saved copy and clears the live code, so the service routine runs in active mode. A sleeping device first passes through a one-cycle wake step. In that step the main clock, sub-main clock and oscillator come back while the CPU is still held off. A return strobe restores the saved code, so the device goes back to sleep by itself. If the routine issues the clear-on-exit command first, the saved copy is zeroed and execution resumes in active mode.

The sequencer has four named states:
- RUN: active, not servicing.
- SLEEP: a low-power code is live.
- WAKE: one cycle in which the clocks restart.
- SERVICE: an interrupt is being handled.

Its transitions are:
- RUN→SLEEP: a write whose code decodes to a low-power mode.
- RUN→SERVICE: an interrupt.
- SLEEP→WAKE: an interrupt.
- WAKE→SERVICE: always, one cycle later.
- SERVICE→RUN: return when the restored code decodes to active.
- SERVICE→SLEEP: return when the restored code decodes to a low-power mode.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: The code is {clock-gen-1, clock-gen-0, oscillator-off, cpu-off}, i.e. bits 3 down to 0. A write in RUN is taken on the clock edge and shows on `live_mode` after that edge. All enable outputs are registered and change only on a clock edge. Reset gives code 0000.
- R2: Code 0000 (active) drives all five enables high.
- R3: Code 0001 turns off the CPU and the main clock. The sub-main clock, the oscillator and the auxiliary clock stay on.
- R4: Code 1101 leaves only the auxiliary clock enabled.
- R5: Code 1111 turns every enable off. Only `irq` can leave this mode.
- R6: Any other code takes the deepest defined mode whose set bits are all present in the code. For example, 0011 and 0111 act as 0001, while 1100 and 1110 act as active.
- R7: An interrupt while sleeping gives one WAKE cycle with enables {cpu,mclk,smclk,osc,aclk} = 01111, and then all five enables high.
- R8: On interrupt entry from RUN or SLEEP, the live code is saved and `live_mode` becomes 0000. From RUN the block enters service in one cycle with all enables high.
- R9: A return strobe during service restores the saved code and the enables that code selects.
- R10: A clear-on-exit during service, either before the return or in the same cycle as the return, zeroes the saved code. After the return the code is 0000 and the block is in RUN.
- R11: Code writes are ignored outside RUN. Return strobes and clear-on-exit are ignored outside SERVICE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_en | input | 1 | Write strobe for the power-control code |
| mode_wr_data | input | 4 | Code to write |
| irq | input | 1 | Qualified interrupt request |
| irq_ret | input | 1 | Interrupt-return strobe |
| clr_on_exit | input | 1 | Zero the saved code before return |
| live_mode | output | 4 | Live power-control code |
| cpu_en | output | 1 | CPU run enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| osc_en | output | 1 | Fast oscillator enable |
| aclk_en | output | 1 | Auxiliary clock enable |

## Verification
The assertions assume that `irq` has already been qualified upstream and that service routines do not nest. They also assume that `irq_ret` and `clr_on_exit` only have meaning during service, which is why every property about them is guarded by the service state. The bench raises `irq` for one cycle at a time and only from RUN or SLEEP. It sends strobes during service, apart from one deliberate out-of-service strobe that checks they are ignored. It never writes a code while the device is waking or servicing.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int CODE_W      = 4;
    localparam int BIT_CPU_OFF = 0;
    localparam int BIT_OSC_OFF = 1;
    localparam int BIT_CG0     = 2;
    localparam int BIT_CG1     = 3;

    typedef enum logic [1:0] {
        PM_ACTIVE,
        PM_LIGHT,
        PM_STANDBY,
        PM_DEEP
    } pmode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_WAKE,
        ST_SERVICE
    } seq_state_e;

    typedef struct packed {
        logic cpu;
        logic mclk;
        logic smclk;
        logic osc;
        logic aclk;
    } clk_en_t;

    localparam clk_en_t EN_ALL  = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1, osc: 1'b1, aclk: 1'b1};
    localparam clk_en_t EN_NONE = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b0, osc: 1'b0, aclk: 1'b0};
endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
    import lpm_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output pmode_e            mode
);
    logic has_light;
    logic has_standby;
    logic has_deep;

    // A defined mode is chosen when all of its set bits appear in the code.
    assign has_light   = code[BIT_CPU_OFF];
    assign has_standby = has_light & code[BIT_CG0] & code[BIT_CG1];
    assign has_deep    = has_standby & code[BIT_OSC_OFF];

    always_comb begin
        if (has_deep) begin
            mode = PM_DEEP;
        end else if (has_standby) begin
            mode = PM_STANDBY;
        end else if (has_light) begin
            mode = PM_LIGHT;
        end else begin
            mode = PM_ACTIVE;
        end
    end
endmodule

// File: rtl/lpm_enable_map.sv
module lpm_enable_map
    import lpm_pkg::*;
(
    input  seq_state_e state,
    input  pmode_e     mode,
    output clk_en_t    en
);
    clk_en_t sleep_en;

    always_comb begin
        unique case (mode)
            PM_ACTIVE:  sleep_en = EN_ALL;
            PM_LIGHT:   sleep_en = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b1, osc: 1'b1, aclk: 1'b1};
            PM_STANDBY: sleep_en = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b0, osc: 1'b0, aclk: 1'b1};
            PM_DEEP:    sleep_en = EN_NONE;
            default:    sleep_en = EN_ALL;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:     en = EN_ALL;
            ST_SLEEP:   en = sleep_en;
            ST_WAKE:    en = '{cpu: 1'b0, mclk: 1'b1, smclk: 1'b1, osc: 1'b1, aclk: 1'b1};
            ST_SERVICE: en = EN_ALL;
            default:    en = EN_ALL;
        endcase
    end
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              irq,
    input  logic              irq_ret,
    input  logic              clr_on_exit,
    output seq_state_e        state_q,
    output seq_state_e        state_d,
    output logic [CODE_W-1:0] live_q,
    output logic [CODE_W-1:0] live_d,
    output logic [CODE_W-1:0] saved_q
);
    logic [CODE_W-1:0] saved_d;
    logic [CODE_W-1:0] ret_code;
    pmode_e            wr_mode;
    pmode_e            ret_mode;

    assign ret_code = clr_on_exit ? '0 : saved_q;

    lpm_mode_decode u_dec_wr (
        .code (wr_code),
        .mode (wr_mode)
    );

    lpm_mode_decode u_dec_ret (
        .code (ret_code),
        .mode (ret_mode)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            live_q  <= '0;
            saved_q <= '0;
        end else begin
            state_q <= state_d;
            live_q  <= live_d;
            saved_q <= saved_d;
        end
    end

    always_comb begin
        state_d = state_q;
        live_d  = live_q;
        saved_d = saved_q;
        unique case (state_q)
            ST_RUN: begin
                if (irq) begin
                    saved_d = live_q;
                    live_d  = '0;
                    state_d = ST_SERVICE;
                end else if (wr_en) begin
                    live_d  = wr_code;
                    state_d = (wr_mode == PM_ACTIVE) ? ST_RUN : ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (irq) begin
                    saved_d = live_q;
                    live_d  = '0;
                    state_d = ST_WAKE;
                end
            end
            ST_WAKE: begin
                state_d = ST_SERVICE;
            end
            ST_SERVICE: begin
                if (clr_on_exit) begin
                    saved_d = '0;
                end
                if (irq_ret) begin
                    live_d  = ret_code;
                    state_d = (ret_mode == PM_ACTIVE) ? ST_RUN : ST_SLEEP;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_en,
    input  logic [CODE_W-1:0] mode_wr_data,
    input  logic              irq,
    input  logic              irq_ret,
    input  logic              clr_on_exit,
    output logic [CODE_W-1:0] live_mode,
    output logic              cpu_en,
    output logic              mclk_en,
    output logic              smclk_en,
    output logic              osc_en,
    output logic              aclk_en
);
    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [CODE_W-1:0] live_q;
    logic [CODE_W-1:0] live_d;
    logic [CODE_W-1:0] saved_q;
    logic              in_svc;
    pmode_e            mode_d;
    clk_en_t           en_d;
    clk_en_t           en_q;

    lpm_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (mode_wr_en),
        .wr_code     (mode_wr_data),
        .irq         (irq),
        .irq_ret     (irq_ret),
        .clr_on_exit (clr_on_exit),
        .state_q     (state_q),
        .state_d     (state_d),
        .live_q      (live_q),
        .live_d      (live_d),
        .saved_q     (saved_q)
    );

    lpm_mode_decode u_dec_live (
        .code (live_d),
        .mode (mode_d)
    );

    lpm_enable_map u_map (
        .state (state_d),
        .mode  (mode_d),
        .en    (en_d)
    );

    // Enables come straight from flops, so they only move on an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= EN_ALL;
        end else begin
            en_q <= en_d;
        end
    end

    assign in_svc    = (state_q == ST_SERVICE);
    assign live_mode = live_q;
    assign cpu_en    = en_q.cpu;
    assign mclk_en   = en_q.mclk;
    assign smclk_en  = en_q.smclk;
    assign osc_en    = en_q.osc;
    assign aclk_en   = en_q.aclk;
endmodule

// File: rtl/lpm_clk_ctrl_sva.sv
module lpm_clk_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       irq_ret,
    input logic       clr_on_exit,
    input logic       mode_wr_en,
    input logic [3:0] live_mode,
    input logic [3:0] saved_code,
    input logic       in_service,
    input logic       cpu_en,
    input logic       mclk_en,
    input logic       smclk_en,
    input logic       osc_en,
    input logic       aclk_en
);
    assert_cpu_needs_mclk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> mclk_en);

    assert_wake_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mclk_en) |=> (mclk_en && !cpu_en) ##1 cpu_en);

    assert_entry_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (live_mode == 4'b0000));

    assert_entry_saves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !in_service && (cpu_en || !mclk_en)) |=> (saved_code == $past(live_mode)));

    assert_return_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && irq_ret && !clr_on_exit) |=> (live_mode == $past(saved_code)));

    assert_clear_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && irq_ret && clr_on_exit) |=> (live_mode == 4'b0000 && cpu_en && !in_service));

    assert_deep_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_mode == 4'b1111) |-> !(cpu_en || mclk_en || smclk_en || osc_en || aclk_en));

    assert_sleep_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_en && mode_wr_en && !irq) |=> $stable(live_mode));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .irq_ret     (irq_ret),
    .clr_on_exit (clr_on_exit),
    .mode_wr_en  (mode_wr_en),
    .live_mode   (live_mode),
    .saved_code  (saved_q),
    .in_service  (in_svc),
    .cpu_en      (cpu_en),
    .mclk_en     (mclk_en),
    .smclk_en    (smclk_en),
    .osc_en      (osc_en),
    .aclk_en     (aclk_en)
);

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr_en = 1'b0;
    logic [3:0] mode_wr_data = 4'b0000;
    logic       irq = 1'b0;
    logic       irq_ret = 1'b0;
    logic       clr_on_exit = 1'b0;
    logic [3:0] live_mode;
    logic       cpu_en, mclk_en, smclk_en, osc_en, aclk_en;
    logic [4:0] en_v;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    lpm_clk_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .irq          (irq),
        .irq_ret      (irq_ret),
        .clr_on_exit  (clr_on_exit),
        .live_mode    (live_mode),
        .cpu_en       (cpu_en),
        .mclk_en      (mclk_en),
        .smclk_en     (smclk_en),
        .osc_en       (osc_en),
        .aclk_en      (aclk_en)
    );

    assign en_v = {cpu_en, mclk_en, smclk_en, osc_en, aclk_en};

    // Expected enables {cpu,mclk,smclk,osc,aclk} for a live code, from R2-R6.
    function automatic logic [4:0] exp_en(input logic [3:0] c);
        if (c == 4'b1111)                   return 5'b00000;
        if (c[3] && c[2] && c[0])           return 5'b00001;
        if (c[0])                           return 5'b00111;
        return 5'b11111;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        check("R1 reset code", live_mode, 4'b0000);
        check("R2 reset enables", en_v, 5'b11111);
    endtask

    task automatic t_write_run(input logic [3:0] code, input string req);
        @(negedge clk);
        mode_wr_en   = 1'b1;
        mode_wr_data = code;
        @(negedge clk);
        mode_wr_en   = 1'b0;
        check("R1 write taken", live_mode, code);
        check(req, en_v, exp_en(code));
    endtask

    task automatic t_wake_from_sleep();
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check("R7 wake enables", en_v, 5'b01111);
        check("R8 entry clears code", live_mode, 4'b0000);
        @(negedge clk);
        check("R7 service enables", en_v, 5'b11111);
    endtask

    task automatic t_irq_from_run();
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check("R8 run entry enables", en_v, 5'b11111);
        check("R8 run entry clears code", live_mode, 4'b0000);
    endtask

    task automatic t_return(input logic [3:0] code);
        @(negedge clk);
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
        check("R9 restored code", live_mode, code);
        check("R9 restored enables", en_v, exp_en(code));
    endtask

    task automatic t_clear_return(input bit same_cycle);
        @(negedge clk);
        clr_on_exit = 1'b1;
        irq_ret     = same_cycle;
        @(negedge clk);
        clr_on_exit = 1'b0;
        if (!same_cycle) begin
            irq_ret = 1'b1;
            @(negedge clk);
        end
        irq_ret = 1'b0;
        check("R10 cleared code", live_mode, 4'b0000);
        check("R10 active enables", en_v, 5'b11111);
        // A write must now be taken, which proves the block is back in RUN.
        t_write_run(4'b1100, "R10 back in run");
        t_write_run(4'b0000, "R2 active enables");
    endtask

    task automatic t_ignore_sleep_write(input logic [3:0] code);
        @(negedge clk);
        mode_wr_en   = 1'b1;
        mode_wr_data = 4'b0000;
        @(negedge clk);
        mode_wr_en   = 1'b0;
        check("R11 sleep write ignored code", live_mode, code);
        check("R11 sleep write ignored enables", en_v, exp_en(code));
    endtask

    task automatic t_ignore_strobes_run();
        t_write_run(4'b1100, "R6 1100 acts active");
        @(negedge clk);
        irq_ret     = 1'b1;
        clr_on_exit = 1'b1;
        @(negedge clk);
        irq_ret     = 1'b0;
        clr_on_exit = 1'b0;
        check("R11 return ignored in run", live_mode, 4'b1100);
        check("R11 run enables kept", en_v, 5'b11111);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        t_write_run(4'b0001, "R3 light mode enables");
        t_wake_from_sleep();
        t_return(4'b0001);
        t_wake_from_sleep();
        t_clear_return(1'b0);

        t_write_run(4'b1101, "R4 standby enables");
        t_ignore_sleep_write(4'b1101);
        t_wake_from_sleep();
        t_return(4'b1101);
        t_wake_from_sleep();
        t_clear_return(1'b1);

        t_write_run(4'b1111, "R5 deep enables");
        repeat (4) @(negedge clk);
        check("R5 deep stays off", en_v, 5'b00000);
        t_wake_from_sleep();
        t_clear_return(1'b0);

        t_write_run(4'b0011, "R6 0011 acts light");
        t_wake_from_sleep();
        t_clear_return(1'b1);
        t_write_run(4'b0111, "R6 0111 acts light");
        t_wake_from_sleep();
        t_clear_return(1'b0);

        t_write_run(4'b1110, "R6 1110 acts active");
        t_irq_from_run();
        t_return(4'b1110);
        t_ignore_strobes_run();

        finish_run();
    end
endmodule